// File: doc/BRIEF.md
# Multi-Register Stack Transfer Sequencer

This block carries out stack push and pop operations for a 32-bit processor with sixteen general registers. A single start pulse hands it a 16-bit selection mask, a direction (push or pop) and the index of the register that acts as stack pointer. The sequencer then walks the selected registers one by one. For each register it moves one longword between the register file and memory and adjusts the stack pointer by four bytes.

A push lowers the stack pointer before each store, and it visits registers from the lowest number upward. A pop loads from the current stack pointer and then raises it, and it visits registers from the highest number downward. A pop with the same mask therefore restores exactly what the matching push saved. The block drives a register-file read port, a register-file write port and a memory request port. Each memory request is held until memory answers with an acknowledge or a bus error.

With zero-wait memory an operation occupies the block for three cycles plus two per selected register. The updated stack pointer is written back to the register file once, at the end of the sequence. A bus error stops the sequence early and raises a fault pulse instead of the done pulse.

Top module: `stk_seq`

## Requirements
- R1: After reset the block is idle: `busy_o`, `done_o`, `fault_o`, `mem_req_o` and `rf_we_o` are low. A `start_i` seen while idle latches `pop_i`, `mask_i` and `sp_sel_i` and raises `busy_o` in the next cycle. A `start_i` seen while busy has no effect.
- R2: Push (`pop_i`=0) handles the mask bits in ascending index order. For each one the stack pointer is first lowered by 4, and then the register is stored (`mem_we_o`=1) at the new stack pointer address.
- R3: Pop (`pop_i`=1) handles the mask bits in descending index order. For each one the register is loaded from the current stack pointer address, and then the stack pointer is raised by 4. A pop with the same mask restores the registers saved by a push.
- R4: At the end of a completed sequence the final stack pointer is written to register `sp_sel_i`. A push of N registers lowers it by 4N and a pop of N registers raises it by 4N.
- R5: When memory acknowledges in the same cycle as the request, `busy_o` stays high for exactly 3 + 2N cycles, where N is the number of mask bits set. `done_o` pulses for one cycle in the last busy cycle.
- R6: An empty mask completes in 3 busy cycles and issues no memory request.
- R7: If the stack-pointer register is in a push mask, the value stored for it is its value from before the sequence. If it is in a pop mask, the final stack-pointer write-back replaces the popped value.
- R8: While `mem_req_o` is high and neither `mem_ack_i` nor `mem_err_i` is high, the request, address, write enable and write data stay unchanged. Each such wait cycle adds one cycle to the sequence.
- R9: `mem_err_i` during a request aborts the sequence. `fault_o` pulses for one cycle in the next cycle and `done_o` is not raised. The stack-pointer register is not written. Registers and memory words transferred before the error keep their new values, and the failed transfer changes nothing.
- R10: The register-file write port and the memory request are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin an operation (taken only when idle) |
| pop_i | input | 1 | Direction: 0 push, 1 pop |
| mask_i | input | 16 | Register selection, bit i selects register i |
| sp_sel_i | input | 4 | Index of the stack-pointer register |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse on normal completion |
| fault_o | output | 1 | One-cycle pulse after a bus error |
| rf_raddr_o | output | 4 | Register-file read index |
| rf_rdata_i | input | 32 | Register-file read data (combinational) |
| rf_we_o | output | 1 | Register-file write enable |
| rf_waddr_o | output | 4 | Register-file write index |
| rf_wdata_o | output | 32 | Register-file write data |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory request is a store |
| mem_addr_o | output | 32 | Byte address of the longword |
| mem_wdata_o | output | 32 | Store data |
| mem_rdata_i | input | 32 | Load data, valid with acknowledge |
| mem_ack_i | input | 1 | Transfer completed |
| mem_err_i | input | 1 | Transfer failed (bus error) |

## Verification
The bench compares every register and memory word against an independent model after each operation. A sequencer that walked the mask in the wrong order, or that updated the stack pointer on the wrong side of the transfer, therefore leaves words at shifted addresses and a mismatched pop. Masks that contain the stack-pointer register itself expose a design that stores the already-decremented pointer, or that lets a popped value survive the final write-back. Stalled acknowledges show whether the request is held and the cycle count stretches by exactly the wait time. Bus errors on the second transfer of a push and of a pop show whether an aborting design wrongly writes back the pointer, commits the failed word, or still signals done.

// File: rtl/stk_seq_pkg.sv
package stk_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD_SP,
        ST_PICK,
        ST_XFER,
        ST_WRITE,
        ST_WB_SP,
        ST_FIN,
        ST_FAULT
    } stk_state_e;

endpackage

// File: rtl/stk_seq_pick.sv
// Priority selector over the set of registers still to transfer.
module stk_seq_pick #(
    parameter int  NREG       = 16,
    parameter bit  HIGH_FIRST = 1'b0,
    localparam int IDX_W      = $clog2(NREG)
) (
    input  logic [NREG-1:0]  vec_i,
    output logic [IDX_W-1:0] idx_o
);

    generate
        if (HIGH_FIRST) begin : g_high
            // later (higher) hits overwrite earlier ones
            always_comb begin
                idx_o = '0;
                for (int i = 0; i < NREG; i++) begin
                    if (vec_i[i]) idx_o = IDX_W'(i);
                end
            end
        end else begin : g_low
            // scan downward so the lowest set bit wins
            always_comb begin
                idx_o = '0;
                for (int i = NREG - 1; i >= 0; i--) begin
                    if (vec_i[i]) idx_o = IDX_W'(i);
                end
            end
        end
    endgenerate

endmodule

// File: rtl/stk_seq_sp_step.sv
// Stack pointer arithmetic and transfer address selection.
module stk_seq_sp_step #(
    parameter int  DATA_W = 32,
    localparam int STEP   = DATA_W / 8
) (
    input  logic [DATA_W-1:0] sp_i,
    input  logic              pop_i,
    output logic [DATA_W-1:0] sp_dec_o,
    output logic [DATA_W-1:0] sp_inc_o,
    output logic [DATA_W-1:0] addr_o
);

    always_comb begin
        sp_dec_o = sp_i - DATA_W'(STEP);
        sp_inc_o = sp_i + DATA_W'(STEP);
        // push stores below the current pointer, pop reads at it
        addr_o   = pop_i ? sp_i : sp_dec_o;
    end

endmodule

// File: rtl/stk_seq.sv
module stk_seq
    import stk_seq_pkg::*;
#(
    parameter int  DATA_W = 32,
    parameter int  NREG   = 16,
    localparam int IDX_W  = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              pop_i,
    input  logic [NREG-1:0]   mask_i,
    input  logic [IDX_W-1:0]  sp_sel_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              fault_o,
    output logic [IDX_W-1:0]  rf_raddr_o,
    input  logic [DATA_W-1:0] rf_rdata_i,
    output logic              rf_we_o,
    output logic [IDX_W-1:0]  rf_waddr_o,
    output logic [DATA_W-1:0] rf_wdata_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [DATA_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic              mem_ack_i,
    input  logic              mem_err_i
);

    typedef struct packed {
        stk_state_e        st;
        logic              pop;
        logic [NREG-1:0]   rem;
        logic [IDX_W-1:0]  spi;
        logic [DATA_W-1:0] sp;
        logic [DATA_W-1:0] data;
    } seq_t;

    seq_t s_q, s_d;

    logic [IDX_W-1:0]  lo_idx, hi_idx, cur_idx;
    logic [NREG-1:0]   rem_clr;
    logic [DATA_W-1:0] sp_dec, sp_inc, xfer_addr;

    stk_seq_pick #(.NREG(NREG), .HIGH_FIRST(1'b0)) u_pick_lo (
        .vec_i (s_q.rem),
        .idx_o (lo_idx)
    );

    stk_seq_pick #(.NREG(NREG), .HIGH_FIRST(1'b1)) u_pick_hi (
        .vec_i (s_q.rem),
        .idx_o (hi_idx)
    );

    stk_seq_sp_step #(.DATA_W(DATA_W)) u_sp (
        .sp_i     (s_q.sp),
        .pop_i    (s_q.pop),
        .sp_dec_o (sp_dec),
        .sp_inc_o (sp_inc),
        .addr_o   (xfer_addr)
    );

    assign cur_idx = s_q.pop ? hi_idx : lo_idx;
    assign rem_clr = s_q.rem & ~(NREG'(1) << cur_idx);

    always_comb begin
        s_d         = s_q;
        rf_raddr_o  = cur_idx;
        rf_we_o     = 1'b0;
        rf_waddr_o  = cur_idx;
        rf_wdata_o  = s_q.data;
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = xfer_addr;
        mem_wdata_o = s_q.data;
        done_o      = 1'b0;
        fault_o     = 1'b0;

        unique case (s_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    s_d.st  = ST_LOAD_SP;
                    s_d.pop = pop_i;
                    s_d.rem = mask_i;
                    s_d.spi = sp_sel_i;
                end
            end
            ST_LOAD_SP: begin
                rf_raddr_o = s_q.spi;
                s_d.sp     = rf_rdata_i;
                if (s_q.rem == '0)  s_d.st = ST_WB_SP;
                else if (s_q.pop)   s_d.st = ST_XFER;
                else                s_d.st = ST_PICK;
            end
            ST_PICK: begin
                // register file still holds pre-sequence values here
                s_d.data = rf_rdata_i;
                s_d.st   = ST_XFER;
            end
            ST_XFER: begin
                mem_req_o = 1'b1;
                mem_we_o  = ~s_q.pop;
                if (mem_err_i) begin
                    s_d.st = ST_FAULT;
                end else if (mem_ack_i) begin
                    if (s_q.pop) begin
                        s_d.data = mem_rdata_i;
                        s_d.st   = ST_WRITE;
                    end else begin
                        s_d.sp  = sp_dec;
                        s_d.rem = rem_clr;
                        s_d.st  = (rem_clr == '0) ? ST_WB_SP : ST_PICK;
                    end
                end
            end
            ST_WRITE: begin
                rf_we_o = 1'b1;
                s_d.sp  = sp_inc;
                s_d.rem = rem_clr;
                s_d.st  = (rem_clr == '0) ? ST_WB_SP : ST_XFER;
            end
            ST_WB_SP: begin
                rf_we_o    = 1'b1;
                rf_waddr_o = s_q.spi;
                rf_wdata_o = s_q.sp;
                s_d.st     = ST_FIN;
            end
            ST_FIN: begin
                done_o = 1'b1;
                s_d.st = ST_IDLE;
            end
            ST_FAULT: begin
                fault_o = 1'b1;
                s_d.st  = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    assign busy_o = (s_q.st != ST_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/stk_seq_chk.sv
module stk_seq_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              fault_o,
    input logic              rf_we_o,
    input logic              mem_req_o,
    input logic              mem_we_o,
    input logic [DATA_W-1:0] mem_addr_o,
    input logic [DATA_W-1:0] mem_wdata_o,
    input logic              mem_ack_i,
    input logic              mem_err_i
);

    p_start_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> busy_o);

    p_done_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);

    p_end_signalled_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(done_o || fault_o));

    p_req_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i && !mem_err_i) |=>
            (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));

    p_err_faults_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_err_i) |=> (fault_o && !done_o));

    p_port_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rf_we_o && mem_req_o));

    p_pulse_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_o, fault_o}));

endmodule

bind stk_seq stk_seq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .fault_o     (fault_o),
    .rf_we_o     (rf_we_o),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_ack_i   (mem_ack_i),
    .mem_err_i   (mem_err_i)
);

// File: tb/stk_seq_bench.sv
module stk_seq_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, pop = 1'b0;
    logic [15:0] mask = '0;
    logic [3:0]  spsel = '0;
    logic        busy, done, fault;
    logic [3:0]  rf_raddr, rf_waddr;
    logic [31:0] rf_rdata, rf_wdata;
    logic        rf_we;
    logic        mem_req, mem_we, mem_ack, mem_err;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    logic [31:0] rf [16];
    logic [31:0] mem [1024];
    logic [31:0] exp_rf [16];
    logic [31:0] exp_mem [1024];

    int          wait_n = 0;
    int          stall = 0;
    logic        err_en = 1'b0;
    logic [31:0] err_addr = '0;

    int errors = 0, checks = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stk_seq u_stk_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .pop_i(pop), .mask_i(mask),
        .sp_sel_i(spsel), .busy_o(busy), .done_o(done), .fault_o(fault),
        .rf_raddr_o(rf_raddr), .rf_rdata_i(rf_rdata), .rf_we_o(rf_we),
        .rf_waddr_o(rf_waddr), .rf_wdata_o(rf_wdata), .mem_req_o(mem_req),
        .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
        .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack), .mem_err_i(mem_err)
    );

    // register file and memory models
    assign rf_rdata  = rf[rf_raddr];
    assign mem_rdata = mem[mem_addr[11:2]];
    wire   hit_err   = err_en && (mem_addr == err_addr);
    assign mem_err   = mem_req && hit_err;
    assign mem_ack   = mem_req && !hit_err && (stall >= wait_n);

    always @(posedge clk) begin
        if (rf_we) rf[rf_waddr] <= rf_wdata;
        if (mem_req && mem_we && mem_ack) mem[mem_addr[11:2]] <= mem_wdata;
        if (mem_req && !mem_ack && !mem_err) stall <= stall + 1;
        else stall <= 0;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic model_op(input bit p, input logic [15:0] m, input int spi);
        logic [31:0] snap [16];
        logic [31:0] sp;
        snap = exp_rf;
        sp = exp_rf[spi];
        if (!p) begin
            for (int i = 0; i < 16; i++)
                if (m[i]) begin sp -= 4; exp_mem[sp[11:2]] = snap[i]; end
        end else begin
            for (int i = 15; i >= 0; i--)
                if (m[i]) begin exp_rf[i] = exp_mem[sp[11:2]]; sp += 4; end
        end
        exp_rf[spi] = sp;
    endtask

    task automatic compare_all(input string req);
        int bad_r = -1, bad_m = -1;
        for (int i = 0; i < 16; i++) if (bad_r < 0 && rf[i] !== exp_rf[i]) bad_r = i;
        for (int i = 0; i < 1024; i++) if (bad_m < 0 && mem[i] !== exp_mem[i]) bad_m = i;
        check(bad_r < 0, req, "register file", bad_r < 0 ? 0 : rf[bad_r],
              bad_r < 0 ? 0 : exp_rf[bad_r]);
        check(bad_m < 0, req, "memory image", bad_m < 0 ? 0 : mem[bad_m],
              bad_m < 0 ? 0 : exp_mem[bad_m]);
    endtask

    task automatic run_op(input bit p, input logic [15:0] m, input logic [3:0] spi,
                          input bit poke, output int cyc, output int dn,
                          output int ft, output int reqs, output int clash);
        cyc = 0; dn = 0; ft = 0; reqs = 0; clash = 0;
        @(negedge clk);
        start = 1'b1; pop = p; mask = m; spsel = spi;
        @(negedge clk);
        start = 1'b0; pop = ~p; mask = ~m; spsel = spi + 4'd1;
        while (busy && cyc < 1000) begin
            cyc++;
            if (done) dn++;
            if (fault) ft++;
            if (mem_req) reqs++;
            if (mem_req && rf_we) clash++;
            start = poke && (cyc == 2);
            @(negedge clk);
        end
        start = 1'b0;
        if (cyc >= 1000) check(0, "R5", "watchdog in operation", cyc, 0);
    endtask

    localparam logic [23:0] VECS [8] = '{
        {1'b0, 16'h002A, 4'd15, 3'd0},
        {1'b1, 16'h002A, 4'd15, 3'd0},
        {1'b0, 16'h0000, 4'd15, 3'd0},
        {1'b0, 16'h8001, 4'd15, 3'd0},
        {1'b1, 16'h8001, 4'd15, 3'd0},
        {1'b0, 16'h0F0F, 4'd3,  3'd2},
        {1'b1, 16'h0F0F, 4'd3,  3'd1},
        {1'b1, 16'hFFFF, 4'd0,  3'd0}
    };

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired: actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        int cyc, dn, ft, reqs, clash, n;
        logic [31:0] spv, keep, save [16];
        for (int i = 0; i < 16; i++) rf[i] = 32'h5A00_0200 + i * 32'h0001_0100;
        rf[15] = 32'h0000_0800;
        rf[3]  = 32'h0000_0600;
        for (int i = 0; i < 1024; i++) mem[i] = 32'hDEAD_0000 + i;
        exp_rf = rf; exp_mem = mem;
        repeat (3) @(negedge clk);
        // R1: idle state under reset
        check(!busy && !done && !fault && !mem_req && !rf_we, "R1", "reset outputs",
              {busy, done, fault, mem_req, rf_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !mem_req && !rf_we, "R1", "idle after reset", {busy, mem_req, rf_we}, 0);

        foreach (VECS[k]) begin
            wait_n = int'(VECS[k][2:0]);
            n = $countones(VECS[k][22:7]);
            model_op(VECS[k][23], VECS[k][22:7], int'(VECS[k][6:3]));
            run_op(VECS[k][23], VECS[k][22:7], VECS[k][6:3], 1'b0, cyc, dn, ft, reqs, clash);
            // R5 cycle count, R8 wait cycles extend it
            check(cyc == 3 + 2*n + n*wait_n, (wait_n != 0) ? "R8" : "R5", "busy cycles",
                  cyc, 3 + 2*n + n*wait_n);
            check(dn == 1 && ft == 0, "R5", "single done pulse", dn, 1);
            check(reqs == n * (1 + wait_n), (n == 0) ? "R6" : "R8", "request cycles",
                  reqs, n * (1 + wait_n));
            check(clash == 0, "R10", "port overlap", clash, 0);
            // R2 push order, R3 pop order, R4 pointer write-back, R7 pointer in mask
            compare_all(VECS[k][23] ? "R3/R4/R7" : "R2/R4/R7");
        end
        wait_n = 0;

        // R3 restore after a matching push
        save = rf;
        model_op(1'b0, 16'h002A, 15);
        run_op(1'b0, 16'h002A, 4'd15, 1'b0, cyc, dn, ft, reqs, clash);
        rf[1] = 32'h0; rf[3] = 32'h1; rf[5] = 32'h2;
        exp_rf = rf;
        model_op(1'b1, 16'h002A, 15);
        run_op(1'b1, 16'h002A, 4'd15, 1'b0, cyc, dn, ft, reqs, clash);
        check(rf[1] == save[1] && rf[3] == save[3] && rf[5] == save[5] && rf[15] == save[15],
              "R3", "restore r5", rf[5], save[5]);
        compare_all("R3");

        // R1: start while busy has no effect
        model_op(1'b0, 16'h0300, 15);
        run_op(1'b0, 16'h0300, 4'd15, 1'b1, cyc, dn, ft, reqs, clash);
        check(cyc == 7, "R1", "cycles with start while busy", cyc, 7);
        repeat (2) @(negedge clk);
        check(!busy, "R1", "no second operation", busy, 0);
        compare_all("R1");

        // R9: bus error on the second store of a push
        spv = rf[15];
        err_addr = spv - 8; err_en = 1'b1;
        keep = mem[err_addr[11:2]];
        run_op(1'b0, 16'h000F, 4'd15, 1'b0, cyc, dn, ft, reqs, clash);
        check(ft == 1 && dn == 0, "R9", "push fault pulse", {dn, ft}, 1);
        check(cyc == 6, "R9", "push abort cycles", cyc, 6);
        check(rf[15] == spv, "R9", "pointer not written", rf[15], spv);
        check(mem[(spv - 4) >> 2 & 1023] == rf[0], "R9", "first store kept",
              mem[(spv - 4) >> 2 & 1023], rf[0]);
        check(mem[err_addr[11:2]] == keep, "R9", "failed store absent",
              mem[err_addr[11:2]], keep);

        // R9: bus error on the second load of a pop
        err_addr = spv + 4;
        keep = rf[4];
        run_op(1'b1, 16'h0030, 4'd15, 1'b0, cyc, dn, ft, reqs, clash);
        check(ft == 1 && dn == 0 && cyc == 5, "R9", "pop fault cycles", cyc, 5);
        check(rf[5] == mem[spv[11:2]], "R9", "first load kept", rf[5], mem[spv[11:2]]);
        check(rf[4] == keep && rf[15] == spv, "R9", "r4 and pointer unchanged", rf[4], keep);
        err_en = 1'b0;

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule